// File: doc/BRIEF.md
# Indexed block-access configuration target for a two-wire management bus

This block is a target on an SMBus-style two-wire bus. It holds the configuration bytes of a clock fan-out buffer: mode bits, per-output enable bits, per-output free-run or stoppable bits, a fixed identification byte, a writable device identifier and a read-length byte. The bus is reached only through indexed block transfers. A host opens a write to select a start index and can then deliver a counted run of bytes. Or it can turn the bus around with a repeated start and read back a count followed by as many bytes as it acknowledges.

SCL and SDA are oversampled by the system clock through a synchronizer chain. Start, repeated start and stop are detected on the synchronized levels. The target only pulls SDA low and releases it during SCL-low time, so an external pull-up and wired-AND bus are assumed. The mode byte and the packed enable and stoppable bits feed the clock-stop controller directly.

Top module: `smbcfg_target`

## Requirements
- R1: After reset, mode_o is 0x00, out_en_o is 4'hF and stoppable_o is 4'hF. A block read returns register 4 = 0x21 (revision 2 in bits 7:4, vendor 1 in bits 3:0), register 5 = 0x01 and register 6 = 0x07.
- R2: The target acknowledges (pulls SDA low in the ninth bit) only the address bytes 0xDC (write) and 0xDD (read). Any other address byte is not acknowledged. Every further byte up to the next start or stop is then not acknowledged and changes no register.
- R3: A write transfer is start, 0xDC, index N, count X, then data bytes. Each of these bytes is acknowledged, and data byte k (k < X) is written into register N+k, with indices counted as in R7.
- R4: During a write, data bytes beyond the count X are not acknowledged and not written. A count of 0 accepts no data byte.
- R5: A read transfer is start, 0xDC, index N, repeated start, 0xDD. The target then sends the value of register 6 as the count byte and follows it with registers N, N+1, … most significant bit first.
- R6: The target keeps sending bytes while the host acknowledges. After a host not-acknowledge it releases SDA and sends nothing more until the next start.
- R7: The index advances by one after each data byte written or sent and wraps from 6 to 0. An index byte of 7 or more selects register 0.
- R8: Write masks: register 0 keeps bits 4 and 3 at 0; registers 1 and 2 keep bits 7, 4, 3 and 0 at 0; writes to register 3 (reserved, reads 0x00) and register 4 (read-only) have no effect. Registers 5 and 6 take all 8 bits.
- R9: mode_o equals register 0 (bit 7 power-down drive mode, bit 6 stop drive mode, bit 5 polarity invert, bit 2 bandwidth select, bit 1 bypass, bit 0 divide-by-two). out_en_o[3:0] are register 1 bits 6, 5, 2, 1 and stoppable_o[3:0] are register 2 bits 6, 5, 2, 1, in that order from bit 3 down to bit 0.
- R10: A stop seen in the middle of a byte ends the transfer without writing the partial byte. The next cycle after any stop, SDA is released.
- R11: The target changes its SDA drive only while the synchronized SCL is low, except for the release at a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| mode_o | output | 8 | Mode register contents |
| out_en_o | output | 4 | Per-output enable bits |
| stoppable_o | output | 4 | Per-output stoppable bits (1 = stoppable, 0 = free-run) |

## Verification
On every cycle the assertions check the bus-discipline rules. SDA drive changes only while SCL is low. SDA is released after a stop. The register index never leaves the implemented range. No register moves without a write strobe. The transfer-level behaviour can only be shown by the bench's scenarios as seen by a bus host: which bytes are acknowledged, the masking of reserved and read-only bits, index wrap, the count byte at the head of a read, silence after a not-acknowledge and the dropped partial byte at a stop.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NOUT   = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_INDEX,
    PH_COUNT,
    PH_WDATA,
    PH_TXCNT,
    PH_TXDATA,
    PH_SKIP
  } phase_e;

  // register bit that feeds output k of the packed enable/stoppable vectors
  function automatic int unsigned out_bit_pos(int unsigned k);
    return (k < 2) ? k + 1 : k + 3;
  endfunction

  // bits a host write may change, per register index
  function automatic logic [BYTE_W-1:0] reg_wmask(int unsigned idx);
    case (idx)
      0:       return 8'hE7;
      1, 2:    return 8'h66;
      5, 6:    return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smbcfg_line_sense.sv
module smbcfg_line_sense #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_sy, sda_sy;
  logic                   scl_prev, sda_prev;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sy <= '1;
          sda_sy <= '1;
        end else begin
          scl_sy <= scl_i;
          sda_sy <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_sy <= '1;
          sda_sy <= '1;
        end else begin
          scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_i};
          sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_lvl;
      sda_prev <= sda_lvl;
    end
  end

  assign scl_lvl   = scl_sy[SYNC_STAGES-1];
  assign sda_lvl   = sda_sy[SYNC_STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/smbcfg_regs.sv
module smbcfg_regs #(
  parameter int unsigned NREG       = 7,
  parameter logic [7:0]  DEV_ID_RST = 8'h01,
  parameter logic [7:0]  VEND_REV   = 8'h21,
  localparam int unsigned AW        = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_idx,
  input  logic [7:0]           wr_data,
  input  logic [AW-1:0]        rd_idx,
  output logic [7:0]           rd_data,
  output logic [NREG-1:0][7:0] regs_o
);

  function automatic logic [7:0] reg_rst(int unsigned idx);
    case (idx)
      1, 2:    return 8'h66;
      4:       return VEND_REV;
      5:       return DEV_ID_RST;
      6:       return 8'h07;
      default: return 8'h00;
    endcase
  endfunction

  logic [NREG-1:0][7:0] regs_q;

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam logic [7:0] MASK = smbcfg_pkg::reg_wmask(g);
      localparam logic [7:0] RSTV = reg_rst(g);
      if (MASK == 8'h00) begin : g_fixed
        assign regs_q[g] = RSTV;
      end else begin : g_rw
        logic [7:0] q, d;
        logic       we;
        assign we = wr_en && (wr_idx == AW'(g));
        assign d  = (wr_data & MASK) | (q & ~MASK);
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            q <= RSTV;
          end else if (we) begin
            q <= d;
          end
        end
        assign regs_q[g] = q;
      end
    end
  endgenerate

  always_comb begin
    rd_data = 8'h00;
    if ({1'b0, rd_idx} < (AW+1)'(NREG)) rd_data = regs_q[rd_idx];
  end

  assign regs_o = regs_q;

  // R2 and R8: registers move only on a write strobe
  a_r2_regs_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q));

endmodule

// File: rtl/smbcfg_target.sv
module smbcfg_target #(
  parameter int unsigned NREG        = 7,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  WR_ADDR     = 8'hDC,
  parameter logic [7:0]  RD_ADDR     = 8'hDD,
  parameter logic [7:0]  DEV_ID_RST  = 8'h01,
  parameter logic [7:0]  VEND_REV    = 8'h21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic [7:0] mode_o,
  output logic [3:0] out_en_o,
  output logic [3:0] stoppable_o
);
  import smbcfg_pkg::*;

  localparam int unsigned AW      = $clog2(NREG);
  localparam int unsigned CNT_IDX = NREG - 1;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  smbcfg_line_sense #(.SYNC_STAGES(SYNC_STAGES)) i_sense (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  phase_e        phase_q, phase_d;
  logic [3:0]    bitcnt_q, bitcnt_d;
  logic          slot9_q, slot9_d;
  logic          dir_q, dir_d;
  logic [7:0]    shreg_q, shreg_d;
  logic [7:0]    tx_q, tx_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [7:0]    left_q, left_d;
  logic          pull_q, pull_d;
  logic          wr_en;
  logic [AW-1:0] rd_idx;
  logic [7:0]    rd_data;
  logic [NREG-1:0][7:0] regs;

  function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
    return (p == AW'(NREG-1)) ? '0 : p + 1'b1;
  endfunction

  assign rd_idx = (phase_q == PH_TXCNT) ? AW'(CNT_IDX) : ptr_q;

  smbcfg_regs #(.NREG(NREG), .DEV_ID_RST(DEV_ID_RST), .VEND_REV(VEND_REV)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(ptr_q), .wr_data(shreg_q),
    .rd_idx(rd_idx), .rd_data(rd_data), .regs_o(regs)
  );

  always_comb begin
    phase_d  = phase_q;
    bitcnt_d = bitcnt_q;
    slot9_d  = slot9_q;
    dir_d    = dir_q;
    shreg_d  = shreg_q;
    tx_d     = tx_q;
    ptr_d    = ptr_q;
    left_d   = left_q;
    pull_d   = pull_q;
    wr_en    = 1'b0;
    if (stop_det || start_det) begin
      phase_d  = stop_det ? PH_IDLE : PH_ADDR;
      pull_d   = 1'b0;
      bitcnt_d = '0;
      slot9_d  = 1'b0;
      dir_d    = 1'b0;
    end else if (phase_q != PH_IDLE && phase_q != PH_SKIP) begin
      if (scl_rise) begin
        if (!slot9_q && bitcnt_q < 4'd8) begin
          if (!dir_q) shreg_d = {shreg_q[6:0], sda_lvl};
          bitcnt_d = bitcnt_q + 4'd1;
        end else if (slot9_q && dir_q && sda_lvl) begin
          phase_d = PH_SKIP;
        end
      end else if (scl_fall) begin
        if (!slot9_q && bitcnt_q == 4'd8) begin
          slot9_d = 1'b1;
          pull_d  = 1'b0;
          if (!dir_q) begin
            case (phase_q)
              PH_ADDR: begin
                if (shreg_q == WR_ADDR) begin
                  phase_d = PH_INDEX;
                  pull_d  = 1'b1;
                end else if (shreg_q == RD_ADDR) begin
                  phase_d = PH_TXCNT;
                  pull_d  = 1'b1;
                end else begin
                  phase_d = PH_SKIP;
                end
              end
              PH_INDEX: begin
                ptr_d   = (shreg_q < 8'(NREG)) ? shreg_q[AW-1:0] : '0;
                phase_d = PH_COUNT;
                pull_d  = 1'b1;
              end
              PH_COUNT: begin
                left_d  = shreg_q;
                phase_d = PH_WDATA;
                pull_d  = 1'b1;
              end
              PH_WDATA: begin
                if (left_q != 8'd0) begin
                  wr_en  = 1'b1;
                  ptr_d  = ptr_next(ptr_q);
                  left_d = left_q - 8'd1;
                  pull_d = 1'b1;
                end else begin
                  phase_d = PH_SKIP;
                end
              end
              default: ;
            endcase
          end
        end else if (slot9_q) begin
          slot9_d  = 1'b0;
          bitcnt_d = '0;
          pull_d   = 1'b0;
          dir_d    = 1'b0;
          if (phase_q == PH_TXCNT || phase_q == PH_TXDATA) begin
            tx_d    = rd_data;
            pull_d  = ~rd_data[7];
            dir_d   = 1'b1;
            phase_d = PH_TXDATA;
            if (phase_q == PH_TXDATA) ptr_d = ptr_next(ptr_q);
          end
        end else if (dir_q && bitcnt_q != 4'd0) begin
          tx_d   = {tx_q[6:0], 1'b0};
          pull_d = ~tx_q[6];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      bitcnt_q <= '0;
      slot9_q  <= 1'b0;
      dir_q    <= 1'b0;
      shreg_q  <= '0;
      tx_q     <= '0;
      ptr_q    <= '0;
      left_q   <= '0;
      pull_q   <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      bitcnt_q <= bitcnt_d;
      slot9_q  <= slot9_d;
      dir_q    <= dir_d;
      shreg_q  <= shreg_d;
      tx_q     <= tx_d;
      ptr_q    <= ptr_d;
      left_q   <= left_d;
      pull_q   <= pull_d;
    end
  end

  assign sda_pull_o = pull_q;
  assign mode_o     = regs[0];

  generate
    for (genvar k = 0; k < NOUT; k++) begin : g_out
      assign out_en_o[k]    = regs[1][out_bit_pos(k)];
      assign stoppable_o[k] = regs[2][out_bit_pos(k)];
    end
  endgenerate

  // R7: index stays inside the implemented registers
  a_r7_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, ptr_q} < (AW+1)'(NREG));

  // R10: stop always leaves SDA released
  a_r10_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull_o);

  // R11: drive moves only with SCL low, apart from start/stop release
  a_r11_drive_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |->
      (!$past(scl_lvl) || $past(stop_det) || $past(start_det)));

endmodule

// File: tb/test_smbcfg_target.sv
module test_smbcfg_target;

  localparam int HALF = 8;

  logic clk, rst_n, scl_h, sda_h;
  logic sda_pull;
  logic [7:0] mode;
  logic [3:0] out_en, stoppable;
  logic sda_bus;

  assign sda_bus = sda_h & ~sda_pull;

  smbcfg_target i_smbcfg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .mode_o(mode), .out_en_o(out_en), .stoppable_o(stoppable)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] exp_reg [0:6];
  logic [7:0] wr_buf [0:7];

  function automatic logic [7:0] wmask(int idx);
    case (idx)
      0: return 8'hE7;
      1, 2: return 8'h66;
      5, 6: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic int nidx(int p);
    return (p >= 6) ? 0 : p + 1;
  endfunction

  function automatic logic [3:0] pack4(logic [7:0] v);
    return {v[6], v[5], v[2], v[1]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; half(); scl_h = 1'b1; half(); sda_h = 1'b0; half(); scl_h = 1'b0; half();
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; half(); scl_h = 1'b1; half(); sda_h = 1'b1; half();
  endtask

  task automatic send_bit(logic b);
    sda_h = b; half(); scl_h = 1'b1; half(); scl_h = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    sda_h = 1'b1; half(); scl_h = 1'b1;
    repeat (HALF/2) @(negedge clk);
    b = sda_bus;
    repeat (HALF/2) @(negedge clk);
    scl_h = 1'b0;
  endtask

  task automatic wbyte(logic [7:0] v, output logic nak);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    get_bit(nak);
  endtask

  task automatic rbyte(logic nak, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      get_bit(b);
      v[i] = b;
    end
    send_bit(nak);
  endtask

  task automatic mdl_write(int idx, logic [7:0] v);
    exp_reg[idx] = (v & wmask(idx)) | (exp_reg[idx] & ~wmask(idx));
  endtask

  // write: index, count, ndata bytes from wr_buf
  task automatic blk_write(logic [7:0] idx, logic [7:0] cnt, int ndata);
    logic nak;
    int p;
    p = (idx < 7) ? int'(idx) : 0;
    bus_start();
    wbyte(8'hDC, nak); chk("R3 write address ack", nak, 0);
    wbyte(idx, nak);   chk("R3 index ack", nak, 0);
    wbyte(cnt, nak);   chk("R3 count ack", nak, 0);
    for (int i = 0; i < ndata; i++) begin
      wbyte(wr_buf[i], nak);
      if (i < int'(cnt)) begin
        chk("R3 data ack", nak, 0);
        mdl_write(p, wr_buf[i]);
        p = nidx(p);
      end else begin
        chk("R4 excess byte nack", nak, 1);
      end
    end
    bus_stop();
    half();
  endtask

  task automatic blk_read(int idx, int n);
    logic nak;
    logic [7:0] v;
    int p;
    p = idx;
    bus_start();
    wbyte(8'hDC, nak); chk("R5 address ack", nak, 0);
    wbyte(8'(idx), nak); chk("R5 index ack", nak, 0);
    bus_start();
    wbyte(8'hDD, nak); chk("R5 read address ack", nak, 0);
    rbyte(1'b0, v);    chk("R5 count byte", v, exp_reg[6]);
    for (int i = 0; i < n; i++) begin
      rbyte(i == n - 1, v);
      chk("R5 R7 R8 read data", v, exp_reg[p]);
      p = nidx(p);
    end
    bus_stop();
    half();
  endtask

  task automatic chk_outs(string req);
    chk(req, mode, exp_reg[0]);
    chk(req, out_en, pack4(exp_reg[1]));
    chk(req, stoppable, pack4(exp_reg[2]));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic nak;
    logic [7:0] v;
    void'($urandom(32'd4711));
    rst_n = 1'b0; scl_h = 1'b1; sda_h = 1'b1;
    exp_reg[0] = 8'h00; exp_reg[1] = 8'h66; exp_reg[2] = 8'h66; exp_reg[3] = 8'h00;
    exp_reg[4] = 8'h21; exp_reg[5] = 8'h01; exp_reg[6] = 8'h07;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 mode reset", mode, 8'h00);
    chk("R1 enable reset", out_en, 4'hF);
    chk("R1 stoppable reset", stoppable, 4'hF);
    chk("R1 released", sda_pull, 0);
    blk_read(0, 7);

    // R2 foreign address
    bus_start();
    wbyte(8'hA0, nak); chk("R2 foreign address nack", nak, 1);
    wbyte(8'h00, nak); chk("R2 following byte nack", nak, 1);
    wbyte(8'hFF, nak); chk("R2 following byte nack", nak, 1);
    bus_stop(); half();
    chk_outs("R2 nothing written");

    // R8 R9 masks and output mapping
    wr_buf[0] = 8'hFF; wr_buf[1] = 8'h40; wr_buf[2] = 8'h02;
    blk_write(0, 3, 3);
    chk("R8 R9 mode masked", mode, 8'hE7);
    chk("R9 enable map", out_en, 4'b1000);
    chk("R9 stoppable map", stoppable, 4'b0001);
    wr_buf[0] = 8'hFF; wr_buf[1] = 8'h00;
    blk_write(3, 2, 2);
    blk_read(3, 2);

    // R4 count limit and zero count
    wr_buf[0] = 8'h11; wr_buf[1] = 8'h22; wr_buf[2] = 8'h33;
    blk_write(5, 2, 3);
    blk_write(0, 0, 1);
    blk_read(5, 2);
    chk_outs("R4 zero count");

    // R7 wrap and out-of-range index
    wr_buf[0] = 8'hA5; wr_buf[1] = 8'h09; wr_buf[2] = 8'h21;
    blk_write(5, 3, 3);
    chk("R7 wrap into reg0", mode, exp_reg[0]);
    wr_buf[0] = 8'h42;
    blk_write(9, 1, 1);
    chk("R7 index 9 selects reg0", mode, 8'h42);
    blk_read(4, 5);

    // R6 silence after nack
    bus_start();
    wbyte(8'hDC, nak); wbyte(8'h00, nak);
    bus_start();
    wbyte(8'hDD, nak);
    rbyte(1'b0, v);
    rbyte(1'b1, v); chk("R6 last byte", v, exp_reg[0]);
    rbyte(1'b1, v); chk("R6 released after nack", v, 8'hFF);
    bus_stop(); half();

    // R10 stop mid-byte
    bus_start();
    wbyte(8'hDC, nak); wbyte(8'h00, nak); wbyte(8'h01, nak);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    bus_stop(); half();
    chk("R10 partial byte dropped", mode, exp_reg[0]);
    chk("R10 released after stop", sda_pull, 0);

    // random mix
    for (int it = 0; it < 20; it++) begin
      int idx, cnt, ridx, rn;
      idx = $urandom_range(0, 8);
      cnt = $urandom_range(1, 4);
      for (int j = 0; j < cnt; j++) wr_buf[j] = 8'($urandom);
      blk_write(8'(idx), 8'(cnt), cnt);
      chk_outs("R9 outputs follow registers");
      ridx = $urandom_range(0, 6);
      rn = $urandom_range(1, 7);
      blk_read(ridx, rn);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule